// File: doc/BRIEF.md
# Two-Phase Bus Master Cycle Engine

This block runs the external bus of an 8-bit processor on behalf of a host that issues one transfer at a time. From a single reference clock input it derives two non-overlapping phase clocks, phase one and phase two. Each transfer starts when phase one rises. The address, the read/write line and the sync strobe are set at that point. Data moves while phase two is high. A ready input can stretch a transfer by whole phase periods.

The host offers a request with a valid/ready handshake. The request carries an address, a direction, a fetch marker and, for writes, a byte. The block takes one request at a time. It starts that request at the next phase-one rise. For a read it returns the captured byte with a one-cycle valid pulse. Write data leaves through a data output with a separate output enable, which a pad ring turns into a tristate bus.

Three active-low asynchronous inputs are watched: a non-maskable interrupt, a maskable interrupt and an overflow-set line. Each has its own sticky flag, which the host clears with a per-flag acknowledge.

Top module: `biphase_bus_master`

## Requirements
- R1: `phi1_o` and `phi2_o` are never high together. `phi2_o` rises only while `phi0_i` is high, and `phi1_o` rises only while `phi0_i` is low. After one phase falls, exactly DEAD clock cycles pass with both phases low before the other phase rises.
- R2: While reset is active, and right after it, these outputs hold fixed values: `phi1_o` high, `phi2_o` low, `req_ready_o` high, `bus_rw_o` high, `bus_sync_o` low, `bus_start_o` low, `data_oe_o` low, `rsp_valid_o` low and `int_flags_o` zero.
- R3: A transfer begins in the clock cycle in which `phi1_o` rises. In that cycle `bus_start_o` pulses for one cycle and `bus_addr_o` shows the requested address. The address then stays unchanged until the transfer ends, including during wait states.
- R4: `bus_rw_o` is high for a read transfer and low for a write transfer (`req_we_i` = 1).
- R5: `bus_sync_o` is high only during read transfers whose request had `req_fetch_i` = 1. It is low for ordinary reads and for every write, including a write with the fetch bit set.
- R6: On a read, the byte on `data_i` is taken at the edge where `phi2_o` falls. It is returned on `rsp_rdata_o` with `rsp_valid_o` high for exactly that one cycle. No other cycle has `rsp_valid_o` high.
- R7: During a write transfer, `data_oe_o` is high exactly while `phi2_o` is high, and `data_o` then carries the request byte. At all other times `data_oe_o` is low.
- R8: `rdy_i` is sampled one clock cycle after `phi2_o` rises. If it was low, the transfer does not end when `phi2_o` falls. Instead it repeats a full phase period with the same address and no new `bus_start_o`. A transfer with N low samples therefore ends on the (N+1)-th fall of `phi2_o`.
- R9: `req_ready_o` goes low at acceptance and stays low until the transfer ends. Only one request is outstanding at a time.
- R10: `int_flags_o[0]` is set on a falling edge of `nmi_n_i`. Writing `int_ack_i[0]` clears it, and it stays clear while the input remains low.
- R11: `int_flags_o[1]` is set whenever `irq_n_i` is low. If `int_ack_i[1]` arrives while the input is still low, the flag stays set. Once the input is high, an acknowledge clears it.
- R12: `int_flags_o[2]` is set on a falling edge of `so_n_i` and cleared by `int_ack_i[2]`. An acknowledge affects only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock that samples everything |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi0_i | input | 1 | External reference clock |
| phi1_o | output | 1 | Phase-one clock |
| phi2_o | output | 1 | Phase-two clock |
| req_valid_i | input | 1 | Host request offered |
| req_ready_o | output | 1 | Block can take a request |
| req_addr_i | input | AW | Request address |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_fetch_i | input | 1 | Marks a read as an opcode fetch |
| req_wdata_i | input | DW | Write byte |
| rsp_valid_o | output | 1 | One-cycle read response strobe |
| rsp_rdata_o | output | DW | Read byte |
| bus_addr_o | output | AW | Bus address |
| bus_rw_o | output | 1 | High read, low write |
| bus_sync_o | output | 1 | Fetch strobe |
| bus_start_o | output | 1 | New-transfer pulse |
| data_i | input | DW | Data bus input from the pad |
| data_o | output | DW | Data bus output to the pad |
| data_oe_o | output | 1 | Pad output enable |
| rdy_i | input | 1 | Ready, low inserts wait states |
| nmi_n_i | input | 1 | Non-maskable interrupt, active low |
| irq_n_i | input | 1 | Maskable interrupt, active low |
| so_n_i | input | 1 | Overflow-set input, active low |
| int_ack_i | input | 3 | Per-flag clear |
| int_flags_o | output | 3 | Sticky flags: bit0 NMI, bit1 IRQ, bit2 SO |

## Verification
The bench builds the block with DEAD = 3, not the default of 2. It drives the reference clock with a half period of 10 system cycles, so the dead-band count and the two-stage edge detection on the reference clock both fit inside each half period with room to spare. With that spacing the ready sample, and up to three repeated data phases, land well inside every phase, so each wait-state length can be told apart. The bench drives `data_i` with a marker value whenever phase two is low. This exposes a capture taken at any edge other than the fall of phase two.

// File: rtl/biphase_bus_master.sv
module biphase_bus_master #(
  parameter int AW   = 16,
  parameter int DW   = 8,
  parameter int DEAD = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          phi0_i,
  output logic          phi1_o,
  output logic          phi2_o,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [AW-1:0] req_addr_i,
  input  logic          req_we_i,
  input  logic          req_fetch_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] bus_addr_o,
  output logic          bus_rw_o,
  output logic          bus_sync_o,
  output logic          bus_start_o,
  input  logic [DW-1:0] data_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  input  logic          rdy_i,
  input  logic          nmi_n_i,
  input  logic          irq_n_i,
  input  logic          so_n_i,
  input  logic [2:0]    int_ack_i,
  output logic [2:0]    int_flags_o
);

  localparam int CW = (DEAD > 1) ? $clog2(DEAD) : 1;
  localparam logic [CW-1:0] CLAST = CW'(DEAD - 1);

  typedef enum logic [1:0] {PH_ONE, PH_GAP12, PH_TWO, PH_GAP21} ph_t;

  ph_t           ph;
  logic [CW-1:0] cnt;
  logic          phi1_q, phi2_q;
  logic [2:0]    p0_sh;

  wire ref_rise = p0_sh[1] & ~p0_sh[2];
  wire ref_fall = ~p0_sh[1] & p0_sh[2];
  wire gap_done = (cnt == CLAST);
  wire phi1_rise_ev = (ph == PH_GAP21) && gap_done;
  wire phi2_rise_ev = (ph == PH_GAP12) && gap_done;
  wire phi2_fall_ev = (ph == PH_TWO) && ref_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) p0_sh <= '0;
    else        p0_sh <= {p0_sh[1:0], phi0_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH_ONE;
      cnt    <= '0;
      phi1_q <= 1'b1;
      phi2_q <= 1'b0;
    end else begin
      case (ph)
        PH_ONE: if (ref_rise) begin
          ph <= PH_GAP12; cnt <= '0; phi1_q <= 1'b0;
        end
        PH_GAP12: if (gap_done) begin
          ph <= PH_TWO; phi2_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
        PH_TWO: if (ref_fall) begin
          ph <= PH_GAP21; cnt <= '0; phi2_q <= 1'b0;
        end
        default: if (gap_done) begin
          ph <= PH_ONE; phi1_q <= 1'b1;
        end else cnt <= cnt + 1'b1;
      endcase
    end
  end

  assign phi1_o = phi1_q;
  assign phi2_o = phi2_q;

  logic          pend, run;
  logic [AW-1:0] pa, addr_q;
  logic          pwe, pfetch, rw_q, sync_q, start_q;
  logic [DW-1:0] pwd, wd_q, rsp_d;
  logic          rsp_v, p2_first, rdy_smp;

  wire accept = req_valid_i & req_ready_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0; run <= 1'b0;
      pa <= '0; pwe <= 1'b0; pfetch <= 1'b0; pwd <= '0;
      addr_q <= '0; rw_q <= 1'b1; sync_q <= 1'b0; wd_q <= '0;
      start_q <= 1'b0; rsp_v <= 1'b0; rsp_d <= '0;
      p2_first <= 1'b0; rdy_smp <= 1'b1;
    end else begin
      start_q  <= 1'b0;
      rsp_v    <= 1'b0;
      p2_first <= phi2_rise_ev;
      if (p2_first) rdy_smp <= rdy_i;
      if (accept) begin
        pend <= 1'b1; pa <= req_addr_i; pwe <= req_we_i;
        pfetch <= req_fetch_i; pwd <= req_wdata_i;
      end
      if (phi1_rise_ev && pend && !run) begin
        run <= 1'b1; pend <= 1'b0; start_q <= 1'b1;
        addr_q <= pa; rw_q <= ~pwe; sync_q <= pfetch & ~pwe; wd_q <= pwd;
      end
      if (phi2_fall_ev && run && rdy_smp) begin
        run <= 1'b0; rw_q <= 1'b1; sync_q <= 1'b0;
        if (rw_q) begin
          rsp_v <= 1'b1; rsp_d <= data_i;
        end
      end
    end
  end

  assign req_ready_o = ~pend & ~run;
  assign bus_addr_o  = addr_q;
  assign bus_rw_o    = rw_q;
  assign bus_sync_o  = sync_q;
  assign bus_start_o = start_q;
  assign rsp_valid_o = rsp_v;
  assign rsp_rdata_o = rsp_d;
  assign data_o      = wd_q;
  assign data_oe_o   = run & ~rw_q & phi2_q;

  logic [2:0] nmi_sh, so_sh;
  logic [1:0] irq_sh;
  logic [2:0] flg;

  wire [2:0] fset = {so_sh[2] & ~so_sh[1], ~irq_sh[1], nmi_sh[2] & ~nmi_sh[1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_sh <= '1; so_sh <= '1; irq_sh <= '1; flg <= '0;
    end else begin
      nmi_sh <= {nmi_sh[1:0], nmi_n_i};
      so_sh  <= {so_sh[1:0], so_n_i};
      irq_sh <= {irq_sh[0], irq_n_i};
      flg    <= fset | (flg & ~int_ack_i);
    end
  end

  assign int_flags_o = flg;

endmodule

// File: rtl/biphase_bus_master_chk.sv
module biphase_bus_master_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          phi1_o,
  input logic          phi2_o,
  input logic          req_ready_o,
  input logic          rsp_valid_o,
  input logic [AW-1:0] bus_addr_o,
  input logic          bus_rw_o,
  input logic          bus_sync_o,
  input logic          bus_start_o,
  input logic          data_oe_o
);

  a_r1_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(phi1_o && phi2_o));

  a_r1_gap_before_phi2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phi2_o) |-> $past(!phi1_o));

  a_r3_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_start_o |-> $stable(bus_addr_o));

  a_r5_sync_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    bus_sync_o |-> bus_rw_o);

  a_r6_rsp_single: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_o |=> !rsp_valid_o);

  a_r7_drive_window: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe_o |-> (phi2_o && !bus_rw_o));

  a_r9_busy_at_start: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start_o |-> !req_ready_o);

endmodule

bind biphase_bus_master biphase_bus_master_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .phi1_o(phi1_o), .phi2_o(phi2_o),
  .req_ready_o(req_ready_o), .rsp_valid_o(rsp_valid_o),
  .bus_addr_o(bus_addr_o), .bus_rw_o(bus_rw_o), .bus_sync_o(bus_sync_o),
  .bus_start_o(bus_start_o), .data_oe_o(data_oe_o)
);

// File: tb/sim_biphase_bus_master.sv
module sim_biphase_bus_master;

  localparam int DEAD_T = 3;
  localparam int HALF   = 10;

  typedef struct {
    logic [15:0] addr;
    logic        we;
    logic        fetch;
    logic [7:0]  wd;
    int          waits;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0, phi0 = 1'b0;
  logic req_valid = 1'b0, req_we = 1'b0, req_fetch = 1'b0, rdy = 1'b1;
  logic nmi_n = 1'b1, irq_n = 1'b1, so_n = 1'b1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic [2:0]  ack = '0;
  logic [7:0]  data_i;
  logic phi1_o, phi2_o, req_ready_o, rsp_valid_o, bus_rw_o, bus_sync_o, bus_start_o, data_oe_o;
  logic [7:0]  rsp_rdata_o, data_o;
  logic [15:0] bus_addr_o;
  logic [2:0]  int_flags_o;

  int nchk = 0, nbad = 0;
  bit done = 0;
  item_t q[$];
  item_t cur;
  bit busy = 0;
  int falls = 0;
  int cur_waits = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] model(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign data_i = phi2_o ? model(bus_addr_o) : 8'hEE;

  biphase_bus_master #(.AW(16), .DW(8), .DEAD(DEAD_T)) u0 (
    .clk(clk), .rst_n(rst_n), .phi0_i(phi0), .phi1_o(phi1_o), .phi2_o(phi2_o),
    .req_valid_i(req_valid), .req_ready_o(req_ready_o), .req_addr_i(req_addr),
    .req_we_i(req_we), .req_fetch_i(req_fetch), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid_o), .rsp_rdata_o(rsp_rdata_o), .bus_addr_o(bus_addr_o),
    .bus_rw_o(bus_rw_o), .bus_sync_o(bus_sync_o), .bus_start_o(bus_start_o),
    .data_i(data_i), .data_o(data_o), .data_oe_o(data_oe_o), .rdy_i(rdy),
    .nmi_n_i(nmi_n), .irq_n_i(irq_n), .so_n_i(so_n), .int_ack_i(ack),
    .int_flags_o(int_flags_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(input logic [15:0] a, input logic we, input logic f, input logic [7:0] wd, input int w);
    item_t it;
    @(negedge clk);
    while (!req_ready_o) @(negedge clk);
    it.addr = a; it.we = we; it.fetch = f; it.wd = wd; it.waits = w;
    q.push_back(it);
    cur_waits = w;
    req_addr = a; req_we = we; req_fetch = f; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready_o, "R9 ready low after accept", req_ready_o, 0);
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      repeat (HALF) @(negedge clk);
      phi0 = ~phi0;
    end
  end

  initial begin
    int  wl = 0;
    logic p2 = 1'b0;
    forever begin
      @(negedge clk);
      if (bus_start_o) begin
        wl = cur_waits;
        rdy = (wl == 0);
      end else if (p2 && !phi2_o && wl > 0) begin
        wl--;
        rdy = (wl == 0);
      end
      p2 = phi2_o;
    end
  end

  initial begin
    logic p1prev = 1'b1, p2prev = 1'b0;
    int lowcnt = 0;
    bit exp_oe;
    @(posedge rst_n);
    forever begin
      @(negedge clk);
      chk(!(phi1_o && phi2_o), "R1 phases overlap", {phi1_o, phi2_o}, 0);
      if (!phi1_o && !phi2_o) lowcnt++;
      else begin
        if (phi2_o && !p2prev) begin
          chk(lowcnt == DEAD_T, "R1 gap before phi2", lowcnt, DEAD_T);
          chk(phi0 == 1'b1, "R1 phi2 follows reference high", phi0, 1);
        end
        if (phi1_o && !p1prev) begin
          chk(lowcnt == DEAD_T, "R1 gap before phi1", lowcnt, DEAD_T);
          chk(phi0 == 1'b0, "R1 phi1 follows reference low", phi0, 0);
        end
        lowcnt = 0;
      end
      if (bus_start_o) begin
        chk(q.size() > 0 && !busy, "R3 unexpected start", busy, 0);
        if (q.size() > 0) begin
          cur = q.pop_front();
          busy = 1; falls = 0;
          chk(phi1_o && !p1prev, "R3 start at phi1 rise", phi1_o, 1);
          chk(bus_addr_o == cur.addr, "R3 address at start", bus_addr_o, cur.addr);
          chk(bus_rw_o == !cur.we, "R4 rw level", bus_rw_o, !cur.we);
          chk(bus_sync_o == (cur.fetch && !cur.we), "R5 sync level", bus_sync_o, cur.fetch && !cur.we);
        end
      end else if (busy) begin
        chk(bus_addr_o == cur.addr, "R3 address held", bus_addr_o, cur.addr);
      end
      exp_oe = busy && cur.we && phi2_o;
      chk(data_oe_o == exp_oe, "R7 output enable", data_oe_o, exp_oe);
      if (data_oe_o) chk(data_o == cur.wd, "R7 write byte", data_o, cur.wd);
      if (busy && p2prev && !phi2_o) begin
        falls++;
        if (falls == cur.waits + 1) begin
          if (!cur.we) begin
            chk(rsp_valid_o, "R6 response pulse", rsp_valid_o, 1);
            chk(rsp_rdata_o == model(cur.addr), "R6 read byte", rsp_rdata_o, model(cur.addr));
          end else
            chk(!rsp_valid_o, "R6 no response for write", rsp_valid_o, 0);
          chk(req_ready_o, "R9 ready after completion", req_ready_o, 1);
          busy = 0;
        end else begin
          chk(!rsp_valid_o, "R8 no response during wait", rsp_valid_o, 0);
          chk(!req_ready_o, "R8 busy during wait", req_ready_o, 0);
        end
      end else begin
        chk(!rsp_valid_o, "R6 stray response", rsp_valid_o, 0);
      end
      p1prev = phi1_o;
      p2prev = phi2_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nbad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end

  initial begin
    waitn(4);
    chk(phi1_o && !phi2_o, "R2 phases in reset", {phi1_o, phi2_o}, 2'b10);
    chk(req_ready_o && bus_rw_o && !bus_sync_o, "R2 bus idle in reset",
        {req_ready_o, bus_rw_o, bus_sync_o}, 3'b110);
    chk(!bus_start_o && !data_oe_o && !rsp_valid_o, "R2 strobes in reset",
        {bus_start_o, data_oe_o, rsp_valid_o}, 0);
    chk(int_flags_o == 3'b000, "R2 flags in reset", int_flags_o, 0);
    rst_n = 1'b1;
    waitn(2);
    chk(req_ready_o && bus_rw_o && !bus_sync_o && int_flags_o == 0, "R2 state after reset",
        {req_ready_o, bus_rw_o, bus_sync_o, int_flags_o}, 6'b110000);

    issue(16'h1234, 1'b0, 1'b0, 8'h00, 0);
    issue(16'hFFFC, 1'b0, 1'b1, 8'h00, 0);
    issue(16'h0200, 1'b1, 1'b0, 8'hA5, 0);
    issue(16'h8001, 1'b1, 1'b0, 8'h3C, 2);
    issue(16'h4000, 1'b0, 1'b0, 8'h00, 3);
    issue(16'h0301, 1'b1, 1'b1, 8'h96, 0);
    issue(16'h9000, 1'b0, 1'b1, 8'h00, 1);
    issue(16'h00FF, 1'b0, 1'b0, 8'h00, 0);
    issue(16'hFFFF, 1'b0, 1'b0, 8'h00, 0);
    issue(16'h0000, 1'b1, 1'b0, 8'hFF, 0);
    while (q.size() != 0 || busy) @(negedge clk);
    waitn(4 * HALF);
    chk(!busy && q.size() == 0, "R9 all transfers completed", q.size(), 0);

    nmi_n = 1'b0; waitn(4);
    chk(int_flags_o == 3'b001, "R10 nmi edge sets flag", int_flags_o, 3'b001);
    ack = 3'b001; waitn(1); ack = 3'b000; waitn(2);
    chk(int_flags_o == 3'b000, "R10 ack clears while held low", int_flags_o, 0);
    waitn(6);
    chk(int_flags_o == 3'b000, "R10 no retrigger on level", int_flags_o, 0);
    nmi_n = 1'b1; waitn(4); nmi_n = 1'b0; waitn(4);
    chk(int_flags_o == 3'b001, "R10 second edge sets flag", int_flags_o, 3'b001);

    irq_n = 1'b0; waitn(4);
    chk(int_flags_o == 3'b011, "R11 irq level sets flag", int_flags_o, 3'b011);
    ack = 3'b010; waitn(1); ack = 3'b000; waitn(2);
    chk(int_flags_o == 3'b011, "R11 flag persists while low", int_flags_o, 3'b011);
    irq_n = 1'b1; waitn(4);
    ack = 3'b010; waitn(1); ack = 3'b000; waitn(2);
    chk(int_flags_o == 3'b001, "R11 ack clears after release", int_flags_o, 3'b001);

    so_n = 1'b0; waitn(4);
    chk(int_flags_o == 3'b101, "R12 so edge sets flag", int_flags_o, 3'b101);
    ack = 3'b100; waitn(1); ack = 3'b000; waitn(2);
    chk(int_flags_o == 3'b001, "R12 ack clears only so", int_flags_o, 3'b001);
    ack = 3'b001; waitn(1); ack = 3'b000; waitn(2);
    chk(int_flags_o == 3'b000, "R12 remaining flag cleared", int_flags_o, 0);
    so_n = 1'b1; nmi_n = 1'b1;
    waitn(4);

    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

endmodule